// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block gathers ten interrupt sources into a single request line for the CPU. Five sources are internal and synchronous: three timer requests and the receive and transmit requests of a serial port. Five are asynchronous external pins. Each source is captured, held as pending and filtered by two masks. The first is a per-source enable mask. The second is a priority threshold that shuts out every source of a lower priority level. The block then picks one winner by a fixed priority order and raises `irq_o` when that winner outranks everything already in service.

The CPU collects the 8-bit type code of the winner in one of two ways. It can pulse `inta_i`, and the code then appears on `vec_o` with a one-cycle `vec_vld_o` strobe. It can instead read the poll register, which acknowledges the winner exactly as `inta_i` does. Acknowledging a source marks it in service, which blocks that source and everything of equal or lower priority. Service nests: a higher-priority source may interrupt an in-service one. Software retires the most urgent in-service source by writing the end-of-interrupt register.

The vector output is a valid-only stream. The CPU always takes the code in the strobe cycle, so there is no ready and no back-pressure. A second acknowledge in the next cycle produces a second strobe. The register bus is plain: writes take effect at the clock edge and read data is combinational.

Top module: `vic_ctrl`

## Requirements
- R1: After reset, `irq_o` and `vec_vld_o` are low. The request and in-service registers read 0. The enable mask (addr 0) reads 0x03FF, with all sources masked. The threshold (addr 1) reads 0xF. The pin mode register (addr 7) reads 0, so every pin is level-sensitive.
- R2: A one-cycle high on an internal source sets that source's request bit (addr 2) at the next edge. The bit stays set until the source is acknowledged. Bit positions are: timer 0..2 at bits 0..2, serial receive at bit 3, serial transmit at bit 4.
- R3: External pins use a two-flop synchronizer. Pin INT4 maps to bit 5 and pins INT0..INT3 map to bits 6..9. Mode bit k of addr 7 selects the mode of pin k, with 1 meaning edge. In level mode the request bit follows the pin two edges later and is not cleared by an acknowledge. In edge mode a rising edge sets the request bit three edges later, and the bit holds until acknowledge.
- R4: A source whose enable-mask bit (addr 0, bit = source index) is 1 still shows its request bit but never causes `irq_o`.
- R5: The priority levels are 2 for bits 0..2, 3 for bits 3..4, and bit index minus 1 for bits 5..9. A source whose level number is greater than the threshold (addr 1, bits 3:0) is blocked. A threshold of 0 or 1 therefore blocks everything.
- R6: Among the eligible sources, the lowest bit index wins.
- R7: `irq_o` is high only when an eligible winner exists and its index is strictly lower than the lowest set in-service bit.
- R8: When `inta_i` is high while `irq_o` is high, `vec_o` = 0x40 + winner index and `vec_vld_o` = 1 in the next cycle. At the same edge the winner's in-service bit (addr 3) is set and its latched request is cleared.
- R9: When `inta_i` is high while `irq_o` is low, `vec_o` returns the spurious code 0xFF with `vec_vld_o`, and the request and in-service registers do not change.
- R10: Any write to addr 6 clears only the lowest-index set in-service bit.
- R11: Addr 5 reads `{irq_o, 7'b0, code}`, where code is the R8 value or 0xFF, and the read has no side effect. Addr 4 reads the same value and acknowledges as in R8 when `irq_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| tmr_req_i | input | 3 | Timer request pulses, timer 0 in bit 0 |
| ser_req_i | input | 2 | Serial receive (bit 0) and transmit (bit 1) requests |
| ext_pin_i | input | 5 | Asynchronous external pins INT0..INT4 |
| inta_i | input | 1 | Hardware acknowledge pulse |
| vec_o | output | 8 | Type code of the acknowledged source |
| vec_vld_o | output | 1 | Strobe marking `vec_o` valid |
| irq_o | output | 1 | Interrupt request to the CPU |
| bus_addr_i | input | 3 | Register address |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data, combinational |

## Verification
A stuck or wrongly set in-service bit shows up at once on `irq_o`, because it changes the nesting comparison in the same cycle. It is also visible on the in-service register at the next read. A pending latch that is not cleared on acknowledge shows on the request register at the read after the acknowledge. It shows again as a repeated code on the next acknowledge. A wrong priority order or threshold decode changes the code returned one cycle after `inta_i`, and the poll-status read shows it with no delay.

// File: rtl/vic_pkg.sv
package vic_pkg;
  localparam int NUM_TMR = 3;
  localparam int NUM_SER = 2;
  localparam int NUM_EXT = 5;
  localparam int NSRC    = NUM_TMR + NUM_SER + NUM_EXT;
  localparam int IDXW    = $clog2(NSRC);
  localparam int LVLW    = 4;

  localparam logic [2:0] A_MASK  = 3'd0;
  localparam logic [2:0] A_THR   = 3'd1;
  localparam logic [2:0] A_REQ   = 3'd2;
  localparam logic [2:0] A_ISR   = 3'd3;
  localparam logic [2:0] A_POLL  = 3'd4;
  localparam logic [2:0] A_PSTAT = 3'd5;
  localparam logic [2:0] A_EOI   = 3'd6;
  localparam logic [2:0] A_MODE  = 3'd7;

  // priority level of a source index: timers share one level, serial the next,
  // each external source gets its own level
  function automatic logic [LVLW-1:0] prio_level(input int idx);
    if (idx < NUM_TMR)                return LVLW'(2);
    else if (idx < NUM_TMR + NUM_SER) return LVLW'(3);
    else                              return LVLW'(idx - 1);
  endfunction
endpackage

// File: rtl/vic_capture.sv
module vic_capture #(
  parameter bit SYNC = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_i,
  input  logic edge_mode_i,
  input  logic clr_i,
  output logic pend_o
);
  generate
    if (SYNC) begin : g_ext
      logic s1_q, s2_q, prev_q, lat_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          s1_q   <= 1'b0;
          s2_q   <= 1'b0;
          prev_q <= 1'b0;
          lat_q  <= 1'b0;
        end else begin
          s1_q   <= raw_i;
          s2_q   <= s1_q;
          prev_q <= s2_q;
          if (!edge_mode_i)                 lat_q <= 1'b0;
          else if (s2_q && !prev_q)         lat_q <= 1'b1;
          else if (clr_i)                   lat_q <= 1'b0;
        end
      end
      assign pend_o = edge_mode_i ? lat_q : s2_q;
    end else begin : g_int
      logic lat_q;
      logic unused_mode;
      assign unused_mode = edge_mode_i;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      lat_q <= 1'b0;
        else if (raw_i)  lat_q <= 1'b1;
        else if (clr_i)  lat_q <= 1'b0;
      end
      assign pend_o = lat_q;
    end
  endgenerate
endmodule

// File: rtl/vic_resolve.sv
module vic_resolve
  import vic_pkg::*;
(
  input  logic [NSRC-1:0] pend_i,
  input  logic [NSRC-1:0] mask_i,
  input  logic [LVLW-1:0] thr_i,
  input  logic [NSRC-1:0] isr_i,
  output logic [IDXW-1:0] win_idx_o,
  output logic            irq_o,
  output logic [NSRC-1:0] eoi_oh_o
);
  logic [NSRC-1:0] elig;
  logic            win_vld, isr_vld;
  logic [IDXW-1:0] isr_idx;

  genvar g;
  generate
    for (g = 0; g < NSRC; g++) begin : g_elig
      assign elig[g] = pend_i[g] & ~mask_i[g] & (prio_level(g) <= thr_i);
    end
  endgenerate

  // scan from lowest priority upward so the lowest index is left standing
  always_comb begin
    win_vld   = 1'b0;
    win_idx_o = '0;
    isr_vld   = 1'b0;
    isr_idx   = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (elig[i]) begin
        win_vld   = 1'b1;
        win_idx_o = IDXW'(i);
      end
      if (isr_i[i]) begin
        isr_vld = 1'b1;
        isr_idx = IDXW'(i);
      end
    end
  end

  assign irq_o    = win_vld & (!isr_vld | (win_idx_o < isr_idx));
  assign eoi_oh_o = isr_vld ? (NSRC'(1) << isr_idx) : '0;
endmodule

// File: rtl/vic_ctrl.sv
module vic_ctrl
  import vic_pkg::*;
#(
  parameter logic [7:0] VEC_BASE = 8'h40,
  parameter logic [7:0] VEC_SPUR = 8'hFF
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_TMR-1:0]   tmr_req_i,
  input  logic [NUM_SER-1:0]   ser_req_i,
  input  logic [NUM_EXT-1:0]   ext_pin_i,
  input  logic                 inta_i,
  output logic [7:0]           vec_o,
  output logic                 vec_vld_o,
  output logic                 irq_o,
  input  logic [2:0]           bus_addr_i,
  input  logic                 bus_wr_i,
  input  logic                 bus_rd_i,
  input  logic [15:0]          bus_wdata_i,
  output logic [15:0]          bus_rdata_o
);
  localparam int EXT0 = NUM_TMR + NUM_SER;

  logic [NSRC-1:0]    mask_q, isr_q, pend, clr, eoi_oh, win_oh;
  logic [LVLW-1:0]    thr_q;
  logic [NUM_EXT-1:0] mode_q;
  logic [NSRC-1:0]    raw, mode_idx;
  logic [IDXW-1:0]    win_idx;
  logic               irq, poll_rd, ack_go, eoi_wr;
  logic [7:0]         vec_now;
  logic               unused_wdata;

  assign unused_wdata = ^bus_wdata_i[15:NSRC];

  // source order equals priority order: pin INT4 sits above pins INT0..INT3
  assign raw      = {ext_pin_i[NUM_EXT-2:0], ext_pin_i[NUM_EXT-1], ser_req_i, tmr_req_i};
  assign mode_idx = {mode_q[NUM_EXT-2:0], mode_q[NUM_EXT-1], {EXT0{1'b0}}};

  genvar g;
  generate
    for (g = 0; g < NSRC; g++) begin : g_src
      vic_capture #(.SYNC(g >= EXT0)) u_cap (
        .clk(clk), .rst_n(rst_n), .raw_i(raw[g]), .edge_mode_i(mode_idx[g]),
        .clr_i(clr[g]), .pend_o(pend[g])
      );
    end
  endgenerate

  vic_resolve u_res (
    .pend_i(pend), .mask_i(mask_q), .thr_i(thr_q), .isr_i(isr_q),
    .win_idx_o(win_idx), .irq_o(irq), .eoi_oh_o(eoi_oh)
  );

  assign poll_rd = bus_rd_i && (bus_addr_i == A_POLL);
  assign eoi_wr  = bus_wr_i && (bus_addr_i == A_EOI);
  assign ack_go  = (inta_i | poll_rd) & irq;
  assign win_oh  = NSRC'(1) << win_idx;
  assign clr     = ack_go ? win_oh : '0;
  assign vec_now = irq ? 8'(VEC_BASE + {{(8-IDXW){1'b0}}, win_idx}) : VEC_SPUR;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q    <= '1;
      thr_q     <= '1;
      mode_q    <= '0;
      isr_q     <= '0;
      vec_o     <= '0;
      vec_vld_o <= 1'b0;
    end else begin
      if (bus_wr_i && bus_addr_i == A_MASK) mask_q <= bus_wdata_i[NSRC-1:0];
      if (bus_wr_i && bus_addr_i == A_THR)  thr_q  <= bus_wdata_i[LVLW-1:0];
      if (bus_wr_i && bus_addr_i == A_MODE) mode_q <= bus_wdata_i[NUM_EXT-1:0];
      isr_q     <= (isr_q & ~(eoi_wr ? eoi_oh : '0)) | clr;
      vec_vld_o <= inta_i;
      if (inta_i) vec_o <= vec_now;
    end
  end

  always_comb begin
    case (bus_addr_i)
      A_MASK:          bus_rdata_o = 16'(mask_q);
      A_THR:           bus_rdata_o = 16'(thr_q);
      A_REQ:           bus_rdata_o = 16'(pend);
      A_ISR:           bus_rdata_o = 16'(isr_q);
      A_POLL, A_PSTAT: bus_rdata_o = {irq, 7'd0, vec_now};
      A_MODE:          bus_rdata_o = 16'(mode_q);
      default:         bus_rdata_o = '0;
    endcase
  end

  assign irq_o = irq;
endmodule

// File: rtl/vic_chk.sv
module vic_chk
  import vic_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            irq,
  input logic            inta,
  input logic            ack_go,
  input logic            eoi_wr,
  input logic [NSRC-1:0] isr,
  input logic [NSRC-1:0] pend,
  input logic [NSRC-1:0] mask,
  input logic [LVLW-1:0] thr,
  input logic [7:0]      vec,
  input logic            vec_vld,
  input logic [7:0]      spur
);
  AST_IRQ_NEEDS_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (pend & ~mask) != '0); // R4
  AST_THR_LOW_SILENCES: assert property (@(posedge clk) disable iff (!rst_n)
    (thr < 4'd2) |-> !irq); // R5
  AST_ACK_ADDS_ISR: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_go && !eoi_wr) |=> $countones(isr) == $past($countones(isr)) + 1); // R8
  AST_STROBE_FOLLOWS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    inta |=> vec_vld); // R8
  AST_SPURIOUS_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (inta && !irq) |=> vec == spur); // R9
  AST_EOI_RETIRES_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_wr && !ack_go && isr != '0) |=> $countones(isr) == $past($countones(isr)) - 1); // R10
  AST_ISR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!ack_go && !eoi_wr) |=> $stable(isr)); // R7
endmodule

bind vic_ctrl vic_chk u_chk (
  .clk(clk), .rst_n(rst_n), .irq(irq), .inta(inta_i), .ack_go(ack_go),
  .eoi_wr(eoi_wr), .isr(isr_q), .pend(pend), .mask(mask_q), .thr(thr_q),
  .vec(vec_o), .vec_vld(vec_vld_o), .spur(VEC_SPUR)
);

// File: tb/sim_vic_ctrl.sv
`timescale 1ns/1ps
module sim_vic_ctrl;
  localparam logic [7:0] BASE = 8'h40;
  localparam logic [7:0] SPUR = 8'hFF;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0] tmr = '0;
  logic [1:0] ser = '0;
  logic [4:0] ext = '0;
  logic inta = 1'b0, wr = 1'b0, rd = 1'b0;
  logic [2:0] addr = '0;
  logic [15:0] wdata = '0;
  logic [7:0] vec;
  logic vld, irq;
  logic [15:0] rdata;

  always #2.5 clk = ~clk;

  vic_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .tmr_req_i(tmr), .ser_req_i(ser), .ext_pin_i(ext),
    .inta_i(inta), .vec_o(vec), .vec_vld_o(vld), .irq_o(irq),
    .bus_addr_i(addr), .bus_wr_i(wr), .bus_rd_i(rd), .bus_wdata_i(wdata),
    .bus_rdata_o(rdata)
  );

  int nvec = 0, nbad = 0;
  bit done = 1'b0;
  logic [9:0] m_lat = '0, m_isr = '0, m_mask = 10'h3FF;
  logic [3:0] m_thr = 4'hF;
  logic [4:0] m_mode = '0;

  function automatic int lvl(input int i);
    return (i < 3) ? 2 : (i < 5) ? 3 : i - 1;
  endfunction

  function automatic int pin_idx(input int k);
    return (k == 4) ? 5 : 6 + k;
  endfunction

  function automatic logic [9:0] pend_exp();
    logic [9:0] p = m_lat;
    for (int k = 0; k < 5; k++)
      if (!m_mode[k] && ext[k]) p[pin_idx(k)] = 1'b1;
    return p;
  endfunction

  function automatic int win_exp();
    logic [9:0] p = pend_exp();
    for (int i = 0; i < 10; i++)
      if (p[i] && !m_mask[i] && lvl(i) <= int'(m_thr)) return i;
    return -1;
  endfunction

  function automatic int isr_low();
    for (int i = 0; i < 10; i++) if (m_isr[i]) return i;
    return 10;
  endfunction

  function automatic bit irq_exp();
    int w = win_exp();
    return (w >= 0) && (w < isr_low());
  endfunction

  function automatic logic [7:0] code_exp();
    return irq_exp() ? 8'(BASE + win_exp()) : SPUR;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic model_ack();
    int w = win_exp();
    if (irq_exp()) begin
      m_isr[w] = 1'b1;
      m_lat[w] = 1'b0;
    end
  endtask

  task automatic bus_wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
    case (a)
      3'd0: m_mask = d[9:0];
      3'd1: m_thr  = d[3:0];
      3'd7: m_mode = d[4:0];
      3'd6: begin int l = isr_low(); if (l < 10) m_isr[l] = 1'b0; end
      default: ;
    endcase
  endtask

  task automatic bus_rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk); addr = a; rd = 1'b1;
    #1 d = rdata;
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic pulse(input int i);
    @(negedge clk);
    if (i < 3) tmr[i] = 1'b1; else ser[i-3] = 1'b1;
    @(negedge clk); tmr = '0; ser = '0;
    m_lat[i] = 1'b1;
  endtask

  task automatic check_all(input string tag);
    logic [15:0] d;
    chk({tag, " irq"}, irq, irq_exp());
    bus_rd(3'd2, d); chk({tag, " req"}, d, 16'(pend_exp()));
    bus_rd(3'd3, d); chk({tag, " isr"}, d, 16'(m_isr));
  endtask

  task automatic do_ack(input string tag);
    logic [7:0] e;
    @(negedge clk); e = code_exp(); inta = 1'b1;
    @(negedge clk); inta = 1'b0;
    chk({tag, " R8 strobe"}, vld, 1'b1);
    chk({tag, " code"}, vec, e);
    model_ack();
  endtask

  task automatic do_poll(input string tag);
    logic [15:0] d, e;
    e = {irq_exp(), 7'd0, code_exp()};
    bus_rd(3'd4, d);
    chk({tag, " R11 poll"}, d, e);
    model_ack();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nbad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 irq", irq, 1'b0);
    chk("R1 vld", vld, 1'b0);
    bus_rd(3'd0, d); chk("R1 mask", d, 16'h03FF);
    bus_rd(3'd1, d); chk("R1 thr", d, 16'h000F);
    bus_rd(3'd7, d); chk("R1 mode", d, 16'h0000);
    check_all("R1");

    // R2/R4: pending recorded while masked
    pulse(0);
    check_all("R2 R4 masked");
    bus_wr(3'd0, 16'h0000);
    chk("R4 unmasked irq", irq, 1'b1);

    // R6/R8/R7/R9
    pulse(3); pulse(2);
    do_ack("R6 timer0 wins");
    check_all("R7 nested block");
    do_ack("R9 spurious");
    check_all("R9 no change");

    // R10 then level threshold R5
    bus_wr(3'd6, 16'h0);
    do_ack("R6 timer2");
    bus_wr(3'd6, 16'h0);
    bus_wr(3'd1, 16'h0002);
    check_all("R5 level3 blocked");
    bus_wr(3'd1, 16'h0003);
    bus_rd(3'd5, d); chk("R11 pstat", d, 16'h8043);
    check_all("R11 pstat no effect");
    do_poll("R11 ack serial rx");
    check_all("R11 after poll");
    bus_wr(3'd6, 16'h0);
    bus_wr(3'd1, 16'h000F);

    // R7 nesting, R10 clears lowest only
    pulse(4);
    do_ack("R8 serial tx");
    pulse(1);
    chk("R7 higher nests", irq, 1'b1);
    do_ack("R7 timer1");
    bus_wr(3'd6, 16'h0);
    check_all("R10 one retired");
    bus_wr(3'd6, 16'h0);
    check_all("R10 all retired");

    // R3 level mode on pin INT0 (bit 6)
    @(negedge clk); addr = 3'd2; rd = 1'b1; ext[0] = 1'b1;
    @(negedge clk); chk("R3 level one edge", rdata[6], 1'b0);
    @(negedge clk); chk("R3 level two edges", rdata[6], 1'b1);
    rd = 1'b0;
    do_ack("R3 level ack");
    check_all("R3 level stays");
    @(negedge clk); ext[0] = 1'b0;
    repeat (3) @(negedge clk);
    bus_wr(3'd6, 16'h0);
    check_all("R3 level dropped");

    // R3 edge mode on pin INT4 (bit 5)
    bus_wr(3'd7, 16'h0010);
    @(negedge clk); addr = 3'd2; rd = 1'b1; ext[4] = 1'b1;
    @(negedge clk);
    @(negedge clk); chk("R3 edge two edges", rdata[5], 1'b0);
    @(negedge clk); chk("R3 edge three edges", rdata[5], 1'b1);
    rd = 1'b0; ext[4] = 1'b0;
    m_lat[5] = 1'b1;
    repeat (3) @(negedge clk);
    check_all("R3 edge held");
    do_ack("R3 edge ack");
    check_all("R3 edge cleared");
    bus_wr(3'd6, 16'h0);
    bus_wr(3'd7, 16'h0000);

    // constrained random over internal sources and register traffic
    for (int n = 0; n < 400; n++) begin
      int op = $urandom % 7;
      case (op)
        0, 1: pulse($urandom % 5);
        2: bus_wr(3'd0, 16'($urandom % 1024));
        3: bus_wr(3'd1, 16'($urandom % 16));
        4: do_ack("R8 R9 rand");
        5: bus_wr(3'd6, 16'h0);
        default: do_poll("R11 rand");
      endcase
      check_all("R6 R7 R10 rand");
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule